// File: doc/BRIEF.md
# Mains Tick Status Register with Vectored Interrupt

This block turns a slow clock taken from the mains supply (50 Hz or 60 Hz) into events that software can see. It brings the raw line signal into the system clock domain, picks out one chosen transition as a single-cycle tick, and records each tick in a sticky monitor flag. It does this whether or not interrupts are enabled. Software reaches the block through one 16-bit register on a simple word/byte bus. The monitor flag sits in the sign bit of the low byte, so a byte test followed by a branch on sign can poll it. Writing that byte with the sign bit at zero clears the flag.

A separate enable bit in the same byte gates an interrupt. When enabled, a tick raises a request that stays up until the processor grants it or until software clears the enable. During the grant cycle the block drives a fixed vector. It also drives a constant priority level at all times. The same register serves a polling mode: software leaves the enable clear, waits for the flag, then clears it.

Top module: `lineclk_irq_ctrl`

## Requirements
- R1: After reset the enable bit, the monitor flag and the interrupt request are all 0, and a read of the register returns 0x0000.
- R2: The register decodes at byte address octal 777546, and address bit 0 is ignored. A read at any other address returns 0x0000, and a write there changes nothing.
- R3: With the default edge selection, a 0-to-1 change of the line input sets the monitor flag at the third rising system clock edge after the change, and not earlier. A 1-to-0 change does not set it.
- R4: The monitor flag is set by a tick whatever the value of the enable bit, and it reads back as bit 7 of the read data.
- R5: A write with byte lane 0 enabled (bus_be[0]=1) and bit 7 of the data at 0 clears the monitor flag. With bit 7 at 1 the flag is left unchanged. If a tick arrives in the same cycle as a clearing write, the flag ends up set.
- R6: Bit 6 is the interrupt enable. A write with bus_be[0]=1 loads it from data bit 6, and it reads back as bit 6. A write with only bus_be[1]=1 changes neither bit 6 nor bit 7.
- R7: Read data bits 15:8 and 5:0 are always 0.
- R8: A tick raises irq_req at the same edge that sets the monitor flag when the enable bit is 1 after that edge. A tick while the enable bit is 0 raises no request.
- R9: A grant (irq_grant=1) while irq_req is 1 clears the request at the next edge. During the grant cycle irq_vector reads octal 100 (decimal 64), and it reads 0 otherwise. irq_level is constant at 6.
- R10: A write that clears the enable bit drops a pending request at the same edge at which the enable bit clears.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_clk_raw | input | 1 | Unsynchronised mains-derived clock |
| bus_addr | input | 18 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte lane enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not selected |
| irq_req | output | 1 | Interrupt request |
| irq_grant | input | 1 | Interrupt grant from the arbiter |
| irq_vector | output | 9 | Vector driven during a granted cycle |
| irq_level | output | 3 | Fixed request priority |

## Verification
The line input is driven with rising and falling changes, and the flag is sampled both one cycle before and at the expected edge. This tells a correct synchroniser depth apart from a shallower or deeper one, and the selected edge apart from the other. Writes go out with every byte-lane combination, at hitting and missing addresses, and with bit 7 set and clear. These separate the clear rule, the enable load and the address decode from one another. Directed cases put a clearing write in the same cycle as a tick, and clear the enable while a request is pending, to pin down the set-over-clear priority and the request drop. A seeded random mix of line changes, writes and grants is then checked against a bench model after every operation.

// File: rtl/lck_pkg.sv
package lck_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_sel_e;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned EN_BIT  = 6;
  localparam int unsigned MON_BIT = 7;
  localparam int unsigned VEC_W   = 9;
  localparam int unsigned LVL_W   = 3;

  localparam logic [VEC_W-1:0] TICK_VECTOR = 9'o100;
  localparam logic [LVL_W-1:0] TICK_LEVEL  = 3'd6;

endpackage

// File: rtl/lck_rst_sync.sv
module lck_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[DEPTH-1];

endmodule

// File: rtl/lck_sync_edge.sv
module lck_sync_edge
  import lck_pkg::*;
#(
  parameter edge_sel_e   EDGE   = EDGE_RISE,
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic tick
);

  logic [STAGES-1:0] meta_q;
  logic [STAGES-1:0] meta_d;
  logic              last_q;
  logic              last_d;
  logic              level;

  assign level = meta_q[STAGES-1];

  always_comb begin
    meta_d = {meta_q[STAGES-2:0], raw_in};
    last_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      last_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      last_q <= last_d;
    end
  end

  generate
    if (EDGE == EDGE_RISE) begin : g_rise
      assign tick = level & ~last_q;
    end else if (EDGE == EDGE_FALL) begin : g_fall
      assign tick = ~level & last_q;
    end else begin : g_both
      assign tick = level ^ last_q;
    end
  endgenerate

endmodule

// File: rtl/lck_csr.sv
module lck_csr
  import lck_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 18,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 18'o777546
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        be,
  input  logic [REG_W-1:0]  wdata,
  input  logic              tick,
  output logic [REG_W-1:0]  rdata,
  output logic              en_q,
  output logic              en_next,
  output logic              mon_q,
  output logic              wr_lo
);

  logic hit;
  logic en_ce;
  logic mon_ce;
  logic mon_next;
  logic unused_bits;

  // word decode: the byte-select address bit is ignored
  assign hit   = (addr[ADDR_W-1:1] == CSR_ADDR[ADDR_W-1:1]);
  assign wr_lo = wr & hit & be[0];

  assign unused_bits = ^{addr[0], be[1], wdata[REG_W-1:MON_BIT+1], wdata[EN_BIT-1:0]};

  always_comb begin
    en_ce    = wr_lo;
    en_next  = en_ce ? wdata[EN_BIT] : en_q;
    mon_ce   = tick | wr_lo;
    if (tick) begin
      mon_next = 1'b1;
    end else if (wr_lo && !wdata[MON_BIT]) begin
      mon_next = 1'b0;
    end else begin
      mon_next = mon_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q <= 1'b0;
    end else if (mon_ce) begin
      mon_q <= mon_next;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && hit) begin
      rdata[EN_BIT]  = en_q;
      rdata[MON_BIT] = mon_q;
    end
  end

endmodule

// File: rtl/lck_irq.sv
module lck_irq
  import lck_pkg::*;
#(
  parameter logic [VEC_W-1:0] VECTOR = TICK_VECTOR,
  parameter logic [LVL_W-1:0] LEVEL  = TICK_LEVEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en_next,
  input  logic             grant,
  output logic             req,
  output logic [VEC_W-1:0] vector,
  output logic [LVL_W-1:0] level
);

  logic req_q;
  logic req_d;

  always_comb begin
    req_d = en_next & (tick | (req_q & ~grant));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req    = req_q;
  assign vector = (grant && req_q) ? VECTOR : '0;
  assign level  = LEVEL;

endmodule

// File: rtl/lineclk_irq_ctrl.sv
module lineclk_irq_ctrl
  import lck_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 18,
  parameter logic [ADDR_W-1:0] CSR_ADDR    = 18'o777546,
  parameter edge_sel_e         TICK_EDGE   = EDGE_RISE,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_clk_raw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_req,
  input  logic              irq_grant,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [LVL_W-1:0]  irq_level
);

  logic rst_int_n;
  logic tick_w;
  logic en_q_w;
  logic en_next_w;
  logic mon_q_w;
  logic wr_lo_w;

  lck_rst_sync #(.DEPTH(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lck_sync_edge #(.EDGE(TICK_EDGE), .STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_in (line_clk_raw),
    .tick   (tick_w)
  );

  lck_csr #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_csr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr    (bus_addr),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .tick    (tick_w),
    .rdata   (bus_rdata),
    .en_q    (en_q_w),
    .en_next (en_next_w),
    .mon_q   (mon_q_w),
    .wr_lo   (wr_lo_w)
  );

  lck_irq #(.VECTOR(TICK_VECTOR), .LEVEL(TICK_LEVEL)) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick_w),
    .en_next (en_next_w),
    .grant   (irq_grant),
    .req     (irq_req),
    .vector  (irq_vector),
    .level   (irq_level)
  );

endmodule

// File: rtl/lck_checker.sv
module lck_checker #(
  parameter int unsigned       VW  = 9,
  parameter logic [VW-1:0]     VEC = 9'o100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          en_q,
  input logic          mon_q,
  input logic          wr_lo,
  input logic          irq_req,
  input logic          irq_grant,
  input logic [VW-1:0] irq_vector,
  input logic [15:0]   bus_rdata
);

  assert_tick_sets_mon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> mon_q);

  assert_tick_raises_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !wr_lo) |=> irq_req);

  assert_req_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en_q);

  assert_grant_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_grant && irq_req && !tick) |=> !irq_req);

  assert_grant_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_grant && irq_req) |-> (irq_vector == VEC));

  assert_idle_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_grant |-> (irq_vector == '0));

  assert_en_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !irq_req);

  assert_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[15:8] == 8'h00) && (bus_rdata[5:0] == 6'h00));

endmodule

bind lineclk_irq_ctrl lck_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .tick       (tick_w),
  .en_q       (en_q_w),
  .mon_q      (mon_q_w),
  .wr_lo      (wr_lo_w),
  .irq_req    (irq_req),
  .irq_grant  (irq_grant),
  .irq_vector (irq_vector),
  .bus_rdata  (bus_rdata)
);

// File: tb/lineclk_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lineclk_irq_ctrl_tb_top;

  localparam logic [17:0] CSR = 18'o777546;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_raw = 1'b0;
  logic [17:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req;
  logic        irq_grant = 1'b0;
  logic [8:0]  irq_vector;
  logic [2:0]  irq_level;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  bit m_en = 1'b0;
  bit m_mon = 1'b0;
  bit m_req = 1'b0;

  always #2 clk = ~clk;

  lineclk_irq_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_clk_raw (line_raw),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_req      (irq_req),
    .irq_grant    (irq_grant),
    .irq_vector   (irq_vector),
    .irq_level    (irq_level)
  );

  function automatic logic [15:0] exp_word(bit en, bit mon);
    logic [15:0] w;
    w = '0;
    w[6] = en;
    w[7] = mon;
    return w;
  endfunction

  function automatic bit addr_hits(logic [17:0] a);
    return a[17:1] == CSR[17:1];
  endfunction

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // read the register at a negedge; compare against model
  task automatic check_reg(string tag);
    bus_addr = CSR;
    bus_rd = 1'b1;
    #1;
    cmp({tag, " rdata"}, bus_rdata, exp_word(m_en, m_mon));
    cmp({tag, " irq_req"}, {15'b0, irq_req}, {15'b0, m_req});
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(logic [17:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    if (addr_hits(a) && be[0]) begin
      m_en = d[6];
      if (!d[7]) m_mon = 1'b0;
      if (!m_en) m_req = 1'b0;
    end
  endtask

  // change line input, wait for the tick to land, update model
  task automatic line_set(bit v);
    bit rise;
    @(negedge clk);
    rise = v && !line_raw;
    line_raw = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (rise) begin
      m_mon = 1'b1;
      if (m_en) m_req = 1'b1;
    end
  endtask

  task automatic grant_pulse(string tag);
    @(negedge clk);
    irq_grant = 1'b1;
    #1;
    cmp({tag, " vector"}, {7'b0, irq_vector}, m_req ? 16'd64 : 16'd0);
    @(negedge clk);
    irq_grant = 1'b0;
    m_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1c7a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_reg("R1 reset");
    cmp("R9 level", {13'b0, irq_level}, 16'd6);

    // R6 enable write
    bus_write(CSR, 2'b01, 16'h0040);
    check_reg("R6 enable set");

    // R3 staged latency of a rising change
    @(negedge clk);
    line_raw = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = CSR; #1;
    cmp("R3 early flag", bus_rdata, 16'h0040);
    bus_rd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_mon = 1'b1; m_req = 1'b1;
    check_reg("R3 R4 R8 tick lands");

    // R9 grant
    grant_pulse("R9 grant");
    check_reg("R9 after grant");
    bus_addr = CSR ^ 18'o10;
    #1;
    cmp("R9 idle vector", {7'b0, irq_vector}, 16'd0);

    // R5 bit7=1 keeps, bit7=0 clears
    bus_write(CSR, 2'b01, 16'h00C0);
    check_reg("R5 keep");
    bus_write(CSR + 18'd1, 2'b01, 16'h0040);
    check_reg("R5 clear via odd byte address R2");

    // R3 falling change sets nothing
    line_set(1'b0);
    check_reg("R3 falling");

    // R6 high lane only
    bus_write(CSR, 2'b10, 16'h0000);
    check_reg("R6 high lane ignored");
    bus_write(CSR, 2'b11, 16'hFFFF);
    check_reg("R7 all ones write");

    // R2 missing address
    bus_write(CSR ^ 18'o4, 2'b11, 16'h0000);
    check_reg("R2 miss write");
    @(negedge clk);
    bus_addr = CSR ^ 18'o4; bus_rd = 1'b1; #1;
    cmp("R2 miss read", bus_rdata, 16'h0000);
    bus_rd = 1'b0;

    // R10 clearing enable drops pending request
    line_set(1'b1);
    check_reg("R10 pending");
    bus_write(CSR, 2'b01, 16'h0080);
    check_reg("R10 dropped");

    // R8 tick while disabled
    line_set(1'b0);
    bus_write(CSR, 2'b01, 16'h0000);
    line_set(1'b1);
    check_reg("R8 R4 disabled tick");

    // R5 tick coincides with clearing write (which also enables)
    line_set(1'b0);
    @(negedge clk);
    line_raw = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = CSR; bus_be = 2'b01; bus_wdata = 16'h0040; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    m_en = 1'b1; m_mon = 1'b1; m_req = 1'b1;
    check_reg("R5 set beats clear");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 4;
      case (op)
        0: line_set(~line_raw);
        1: grant_pulse("R9 random grant");
        default: begin
          logic [17:0] a;
          a = ($urandom % 2) ? CSR : (CSR ^ (18'd2 << ($urandom % 16)));
          bus_write(a, 2'($urandom), 16'($urandom));
        end
      endcase
      check_reg("R2 R5 R6 R8 random");
    end

    summary();
    $finish;
  end

endmodule